// File: doc/BRIEF.md
# Dual-Mode FIFO Read Output Stage

This block is the read half of a single-clock FIFO. It owns a small register array with a write stub, the read pointer and the word count, and the output register that drives the user's data bus. One active-low status pin carries one of two meanings, chosen by a mode input that is captured only while the synchronous reset is held.

In standard mode the pin is an empty flag: it is low while no word can be read. A read (read enable low while the flag is high) places the head word on the data output at that clock edge. In fall-through mode the block fetches the head word into the output register without being asked. The pin is then an output-ready flag: it is low while the output register holds a word nobody has taken. A read then consumes the presented word and refills the register when another word is stored. Because the output register holds a word in this mode, the FIFO holds one more word in fall-through mode than in standard mode.

Top module: `fifo_rd_stage`

## Requirements
- R1: While reset (rst_n low at a rising edge) is held, the data output is 0 and the flag is in its idle state: low in standard mode, high in fall-through mode. The mode input is captured at those edges (0 = standard, 1 = fall-through).
- R2: In standard mode the flag is low whenever no word is stored. A read request at an edge where the flag is low leaves the data output unchanged.
- R3: In standard mode, after a write edge into an empty FIFO the flag goes high one edge later. Each read at an edge with the flag high puts the oldest stored word on the data output at that edge, so words leave in write order. The read that takes the last word drives the flag low at the same edge.
- R4: In fall-through mode, the first word written into an empty FIFO appears on the data output at the same edge the flag goes low, two edges after the write edge (one edge later than in standard mode).
- R5: In fall-through mode the flag stays low across the edge that moves the last stored word into the output register. It goes high only at an edge where read enable is low.
- R6: In fall-through mode, once the last word has been taken the data output keeps that word. Reads while the flag is high change neither the data output nor the flag.
- R7: The FIFO holds DEPTH words in standard mode and DEPTH+1 words in fall-through mode. A write arriving when the array already holds DEPTH words is dropped.
- R8: Changes on the mode input while reset is not held have no effect on behaviour.
- R9: In fall-through mode, a read at an edge where further words are stored loads the next word into the output register at that edge, and the flag stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock, rising-edge active (also clocks the write stub) |
| rst_n | input | 1 | Synchronous reset, active low |
| fwft_mode_i | input | 1 | Mode select captured during reset: 0 standard, 1 fall-through |
| wr_en_i | input | 1 | Write-stub enable, active high |
| wr_data_i | input | W | Write-stub data |
| rd_en_n_i | input | 1 | Read enable, active low |
| rd_data_o | output | W | Registered data output |
| flag_n_o | output | 1 | Empty flag (standard mode) or output-ready flag (fall-through mode), active low |

## Verification
In standard mode a write is reflected on the flag one edge after the write edge. A read's word and any flag drop are due at the read edge itself. In fall-through mode the first word and the falling flag are due two edges after the write edge, and every later read shows its result at the read edge. The bench drives on the falling clock edge and samples one falling edge after each rising edge it counts. It checks the intermediate edges as well, so a flag that arrives early or late is caught. The scoreboard holds the words written in order, and each read result is compared with the head of that queue.

// File: rtl/frs_pkg.sv
package frs_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } frs_mode_e;

  // next occupancy of the storage array
  function automatic int unsigned occ_next(int unsigned occ, logic push, logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // pointer advance with wrap at the array depth
  function automatic int unsigned ptr_next(int unsigned ptr, int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/frs_store.sv
module frs_store #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          pop,
  output logic [W-1:0]  head_data,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] occ_nxt
);
  import frs_pkg::*;

  localparam logic [CW-1:0] FULL_OCC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_acc;

  assign wr_acc    = wr_en && (occ != FULL_OCC);
  assign occ_nxt   = CW'(occ_next(32'(occ), wr_acc, pop));
  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      occ <= occ_nxt;
      if (wr_acc) wr_ptr <= AW'(ptr_next(32'(wr_ptr), DEPTH));
      if (pop)    rd_ptr <= AW'(ptr_next(32'(rd_ptr), DEPTH));
    end
  end

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= wr_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_OCC); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> occ != '0); // R2
endmodule

// File: rtl/frs_avail.sv
module frs_avail #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] occ,
  input  logic [CW-1:0] occ_nxt,
  output logic          avail_q
);
  // set one edge after the array becomes non-empty, cleared at the edge that empties it
  always_ff @(posedge clk) begin
    if (!rst_n) avail_q <= 1'b0;
    else        avail_q <= (occ != '0) && (occ_nxt != '0);
  end

  AST_AVAIL_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    avail_q |-> occ != '0); // R3
endmodule

// File: rtl/frs_outreg.sv
module frs_outreg #(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  frs_pkg::frs_mode_e mode,
  input  logic            avail_q,
  input  logic            rd_en_n,
  input  logic [W-1:0]    head_data,
  output logic            pop,
  output logic [W-1:0]    data_q,
  output logic            flag_n
);
  import frs_pkg::*;

  logic valid_q;
  logic rd_req;
  logic drop_valid;

  assign rd_req = !rd_en_n;

  always_comb begin
    pop        = 1'b0;
    drop_valid = 1'b0;
    if (mode == MODE_STD) begin
      pop = rd_req && avail_q;
    end else begin
      pop        = avail_q && (!valid_q || rd_req);
      drop_valid = valid_q && rd_req && !avail_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (pop) data_q <= head_data;
      if (mode == MODE_FWFT) begin
        if (pop)             valid_q <= 1'b1;
        else if (drop_valid) valid_q <= 1'b0;
      end
    end
  end

  assign flag_n = (mode == MODE_STD) ? avail_q : !valid_q;

  AST_STD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STD && !flag_n) |=> $stable(data_q)); // R2
  AST_FWFT_READY_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FWFT && $fell(flag_n)) |-> $past(pop)); // R4
  AST_FWFT_RISE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FWFT && $rose(flag_n)) |-> $past(!rd_en_n)); // R5
  AST_FWFT_HOLD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FWFT && $rose(flag_n)) |-> $stable(data_q)); // R6
endmodule

// File: rtl/fifo_rd_stage.sv
module fifo_rd_stage #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fwft_mode_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_n_i,
  output logic [W-1:0] rd_data_o,
  output logic         flag_n_o
);
  import frs_pkg::*;

  frs_mode_e      mode_q;
  logic [W-1:0]   head_data;
  logic [CW-1:0]  occ, occ_nxt;
  logic           avail_q;
  logic           pop;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= fwft_mode_i ? MODE_FWFT : MODE_STD;
  end

  frs_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_data(wr_data_i),
    .pop(pop), .head_data(head_data), .occ(occ), .occ_nxt(occ_nxt)
  );

  frs_avail #(.CW(CW)) u_avail (
    .clk(clk), .rst_n(rst_n), .occ(occ), .occ_nxt(occ_nxt), .avail_q(avail_q)
  );

  frs_outreg #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .avail_q(avail_q),
    .rd_en_n(rd_en_n_i), .head_data(head_data), .pop(pop),
    .data_q(rd_data_o), .flag_n(flag_n_o)
  );

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q)); // R8
endmodule

// File: tb/fifo_rd_stage_tb.sv
module fifo_rd_stage_tb;
  localparam int W = 8;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwft_mode_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic rd_en_n_i = 1'b1;
  logic [W-1:0] rd_data_o;
  logic flag_n_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [W-1:0] sb_q[$];

  fifo_rd_stage #(.W(W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .fwft_mode_i(fwft_mode_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_en_n_i(rd_en_n_i), .rd_data_o(rd_data_o),
    .flag_n_o(flag_n_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0;
    fwft_mode_i = mode;
    tick();
    tick();
    rst_n = 1'b1;
    fwft_mode_i = ~mode;   // must be ignored from here on (R8)
    sb_q.delete();
  endtask

  // driver: one write edge, queue the word if it is expected to be kept
  task automatic write_word(input logic [W-1:0] v, input bit keep);
    wr_en_i = 1'b1;
    wr_data_i = v;
    tick();
    wr_en_i = 1'b0;
    if (keep) sb_q.push_back(v);
  endtask

  // standard-mode read: result due at the read edge
  task automatic read_std(input string tag);
    logic [W-1:0] exp_v;
    rd_en_n_i = 1'b0;
    tick();
    rd_en_n_i = 1'b1;
    exp_v = sb_q.pop_front();
    check(rd_data_o == exp_v, tag, int'(rd_data_o), int'(exp_v));
  endtask

  // fall-through read: compare the presented word, then consume it
  task automatic read_fwft(input string tag);
    logic [W-1:0] exp_v;
    exp_v = sb_q.pop_front();
    check(flag_n_o == 1'b0, {tag, " ready"}, int'(flag_n_o), 0);
    check(rd_data_o == exp_v, tag, int'(rd_data_o), int'(exp_v));
    rd_en_n_i = 1'b0;
    tick();
    rd_en_n_i = 1'b1;
  endtask

  initial begin
    // ---------------- standard mode ----------------
    do_reset(1'b0);
    check(rd_data_o == 0, "R1 std data", int'(rd_data_o), 0);
    check(flag_n_o == 1'b0, "R1 std flag", int'(flag_n_o), 0);
    rd_en_n_i = 1'b0; tick(); rd_en_n_i = 1'b1;
    check(rd_data_o == 0, "R2 read while empty", int'(rd_data_o), 0);
    check(flag_n_o == 1'b0, "R2 flag empty", int'(flag_n_o), 0);
    write_word(8'hA1, 1'b1);
    check(flag_n_o == 1'b0, "R3 flag not yet", int'(flag_n_o), 0);
    tick();
    check(flag_n_o == 1'b1, "R3 flag after one edge", int'(flag_n_o), 1);
    check(rd_data_o == 0, "R8 no fall-through", int'(rd_data_o), 0);
    write_word(8'hB2, 1'b1);
    tick();
    read_std("R3 first word");
    check(flag_n_o == 1'b1, "R3 flag still high", int'(flag_n_o), 1);
    read_std("R3 last word");
    check(flag_n_o == 1'b0, "R3 flag low at last read", int'(flag_n_o), 0);
    rd_en_n_i = 1'b0; tick(); rd_en_n_i = 1'b1;
    check(rd_data_o == 8'hB2, "R2 blocked read", int'(rd_data_o), 8'hB2);

    // capacity, standard: DEPTH words kept
    for (int i = 0; i < DEPTH + 3; i++) write_word(W'(8'h10 + i), i < DEPTH);
    tick(); tick();
    for (int i = 0; i < DEPTH; i++) read_std("R7 std drain");
    check(flag_n_o == 1'b0, "R7 std empty after DEPTH", int'(flag_n_o), 0);

    // ---------------- fall-through mode ----------------
    do_reset(1'b1);
    check(rd_data_o == 0, "R1 fwft data", int'(rd_data_o), 0);
    check(flag_n_o == 1'b1, "R1 fwft flag", int'(flag_n_o), 1);
    write_word(8'h5C, 1'b1);
    check(flag_n_o == 1'b1, "R4 not ready edge 0", int'(flag_n_o), 1);
    tick();
    check(flag_n_o == 1'b1, "R4 not ready edge 1", int'(flag_n_o), 1);
    tick();
    check(flag_n_o == 1'b0, "R4 ready edge 2", int'(flag_n_o), 0);
    check(rd_data_o == 8'h5C, "R4 data with ready", int'(rd_data_o), 8'h5C);
    write_word(8'h6D, 1'b1);
    write_word(8'h7E, 1'b1);
    tick(); tick();
    read_fwft("R9 word a");
    read_fwft("R9 word b");
    check(flag_n_o == 1'b0, "R5 ready holds on last word", int'(flag_n_o), 0);
    read_fwft("R5 last word");
    check(flag_n_o == 1'b1, "R5 not ready after read", int'(flag_n_o), 1);
    check(rd_data_o == 8'h7E, "R6 data held", int'(rd_data_o), 8'h7E);
    rd_en_n_i = 1'b0; tick(); tick(); rd_en_n_i = 1'b1;
    check(rd_data_o == 8'h7E, "R6 ignored read data", int'(rd_data_o), 8'h7E);
    check(flag_n_o == 1'b1, "R6 ignored read flag", int'(flag_n_o), 1);

    // capacity, fall-through: DEPTH+1 words kept
    for (int i = 0; i < DEPTH + 3; i++) write_word(W'(8'h40 + i), i < DEPTH + 1);
    tick(); tick(); tick();
    for (int i = 0; i < DEPTH + 1; i++) read_fwft("R7 fwft drain");
    check(flag_n_o == 1'b1, "R7 fwft empty after DEPTH+1", int'(flag_n_o), 1);
    check(sb_q.size() == 0, "R7 scoreboard drained", sb_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule